// File: doc/BRIEF.md
# Down-Counting Timer Channel with Input Capture

This block is one 32-bit timer channel. A counter counts down by one on each qualified count tick. On a tick that finds the counter at zero, the counter reloads from a constant register and an underflow flag is raised. The underflow flag, gated by an enable bit, drives the interrupt output.

A 3-bit source code picks the count tick. The choices are five binary-power divisions of the peripheral clock, a tick from a real-time-clock pulse input, and edges on an external pin. The external pin passes through a synchronizer. A 2-bit edge field then selects which pin transitions count as events. The same pin events can also freeze the counter value into a read-only capture register.

While module standby is asserted, only the real-time-clock source keeps the channel running. Software reaches the channel through a small word-addressed register port: a single-cycle write strobe and a combinational read.

Top module: `capture_down_timer`

## Requirements
- R1: During reset the control word reads 0, the counter and reload registers read all ones, the capture register reads 0 and `irq` is low. The register addresses are 0 control, 1 counter, 2 reload and 3 capture. The control bits are [0] interrupt enable, [2:1] edge select, [5:3] source code, [6] capture enable, [7] underflow flag and [8] capture flag.
- R2: Source codes 0 to 4 divide the clock by 4, 16, 64, 256 and 1024. A control write restarts the divider, so the first decrement happens exactly N cycles after the control write edge, and further decrements follow every N cycles.
- R3: A tick on a nonzero counter decrements it by one. A tick on a zero counter loads the reload value and sets the underflow flag.
- R4: `irq` is high exactly when the underflow flag and the interrupt enable are both 1.
- R5: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves the flag unchanged.
- R6: Source code 5 produces no ticks.
- R7: Source code 6 decrements once per single-cycle `rtc_tick` pulse.
- R8: Source code 7 counts events on `ext_pin`. Edge select 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both. A pin change made before clock edge E0 updates the counter at edge E2.
- R9: When capture is enabled, a selected pin event copies the counter into the capture register and sets the capture flag. This happens only while the capture flag is 0. When capture is disabled, no capture occurs.
- R10: While `standby` is high, the counter holds unless source code 6 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| ext_pin | input | 1 | External count / capture pin |
| standby | input | 1 | Module standby request |
| rtc_tick | input | 1 | Single-cycle real-time-clock tick |
| irq | output | 1 | Underflow interrupt |

## Verification
Register writes and RTC pulses take effect at the clock edge that samples them. The bench therefore reads the result at the next falling edge. A divided source first decrements N edges after the control write. The bench checks that the value is unchanged at edge N-1 and has decremented at edge N, and then again one period later. Pin events pass two synchronizer flops and an edge register, so the bench checks that the counter is still unchanged two edges after a pin change and has moved on the third. Capture checks wait until the third edge has passed.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   localparam int NUM_DIV   = 5;
   localparam int CTRL_W    = 9;
   localparam logic [2:0] SRC_RSVD = 3'd5;
   localparam logic [2:0] SRC_RTC  = 3'd6;
   localparam logic [2:0] SRC_EXT  = 3'd7;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_CNT  = 2'd1;
   localparam logic [1:0] A_RLD  = 2'd2;
   localparam logic [1:0] A_CAP  = 2'd3;

   typedef struct packed {
      logic       cap_flag;
      logic       uf_flag;
      logic       cap_en;
      logic [2:0] src;
      logic [1:0] edge_sel;
      logic       irq_en;
   } ctrl_t;
endpackage

// File: rtl/cdt_edge.sv
module cdt_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       pin,
   input  logic [1:0] edge_sel,
   output logic       evt
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cdt_edge: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) sync_q[0] <= 1'b0;
            else     sync_q[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) sync_q[i] <= 1'b0;
            else     sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= sync_q[SYNC_STAGES-1];
   end

   logic rise, fall;
   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
   assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

   always_comb begin
      if (edge_sel[1])      evt = rise | fall;
      else if (edge_sel[0]) evt = fall;
      else                  evt = rise;
   end
endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale
   import cdt_pkg::*;
#(
   parameter int N_DIV = NUM_DIV
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       restart,
   input  logic [2:0] src,
   input  logic       standby,
   input  logic       rtc_tick,
   input  logic       ext_evt,
   output logic       tick
);
   localparam int DIV_W = 2 * N_DIV;

   if (N_DIV < 1 || N_DIV > 5) begin : g_bad_div
      $error("cdt_prescale: N_DIV must be between 1 and 5");
   end

   logic [DIV_W-1:0] div_q;
   logic [N_DIV-1:0] hit;

   always_ff @(posedge clk) begin
      if (rst || restart) div_q <= '0;
      else if (!standby)  div_q <= div_q + 1'b1;
   end

   // Division k ends when its low 2k+2 divider bits are all ones.
   for (genvar k = 0; k < N_DIV; k++) begin : g_hit
      assign hit[k] = &div_q[2*k+1:0];
   end

   logic raw;
   always_comb begin
      raw = 1'b0;
      if (src == SRC_EXT)              raw = ext_evt;
      else if (int'(src) < N_DIV)      raw = hit[src];
   end

   assign tick = (src == SRC_RTC) ? rtc_tick : (raw & ~standby);

   // R10
   standby_halt_chk: assert property (@(posedge clk) disable iff (rst)
      (standby && src != SRC_RTC) |-> !tick);
   // R6
   reserved_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (src == SRC_RSVD) |-> !tick);
endmodule

// File: rtl/capture_down_timer.sv
module capture_down_timer
   import cdt_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       addr,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data,
   input  logic             ext_pin,
   input  logic             standby,
   input  logic             rtc_tick,
   output logic             irq
);
   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("capture_down_timer: CNT_W must hold the control word");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cnt_q, rld_q, cap_q;
   logic             tick, evt;
   logic             wr_ctrl, wr_cnt, wr_rld;

   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign wr_cnt  = wr_en && (addr == A_CNT);
   assign wr_rld  = wr_en && (addr == A_RLD);

   cdt_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
      .clk(clk), .rst(rst), .pin(ext_pin),
      .edge_sel(ctrl_q.edge_sel), .evt(evt)
   );

   cdt_prescale #(.N_DIV(NUM_DIV)) i_pre (
      .clk(clk), .rst(rst), .restart(wr_ctrl), .src(ctrl_q.src),
      .standby(standby), .rtc_tick(rtc_tick), .ext_evt(evt), .tick(tick)
   );

   logic uf_set, cap_load;
   assign uf_set   = tick && (cnt_q == '0) && !wr_cnt;
   assign cap_load = ctrl_q.cap_en && evt && !ctrl_q.cap_flag;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.irq_en   <= wr_data[0];
            ctrl_q.edge_sel <= wr_data[2:1];
            ctrl_q.src      <= wr_data[5:3];
            ctrl_q.cap_en   <= wr_data[6];
            if (!wr_data[7]) ctrl_q.uf_flag  <= 1'b0;
            if (!wr_data[8]) ctrl_q.cap_flag <= 1'b0;
         end
         if (uf_set)   ctrl_q.uf_flag  <= 1'b1;
         if (cap_load) ctrl_q.cap_flag <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '1;
         rld_q <= '1;
         cap_q <= '0;
      end else begin
         if (wr_rld) rld_q <= wr_data;
         if (wr_cnt)              cnt_q <= wr_data;
         else if (tick) begin
            if (cnt_q == '0) cnt_q <= rld_q;
            else             cnt_q <= cnt_q - 1'b1;
         end
         if (cap_load) cap_q <= cnt_q;
      end
   end

   always_comb begin
      unique case (addr)
         A_CTRL:  rd_data = CNT_W'(ctrl_q);
         A_CNT:   rd_data = cnt_q;
         A_RLD:   rd_data = rld_q;
         default: rd_data = cap_q;
      endcase
   end

   assign irq = ctrl_q.uf_flag & ctrl_q.irq_en;

   // R3
   underflow_reload_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && cnt_q == '0 && !wr_cnt) |=> (ctrl_q.uf_flag && cnt_q == $past(rld_q)));
   // R3
   decrement_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && cnt_q != '0 && !wr_cnt) |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R9
   capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl_q.cap_flag |=> $stable(cap_q));
   // R4
   irq_source_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq) |-> (ctrl_q.irq_en && ctrl_q.uf_flag));
endmodule

// File: tb/test_capture_down_timer.sv
module test_capture_down_timer;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        ext_pin = 1'b0;
   logic        standby = 1'b0;
   logic        rtc_tick = 1'b0;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   capture_down_timer i_capture_down_timer (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .ext_pin(ext_pin), .standby(standby),
      .rtc_tick(rtc_tick), .irq(irq)
   );

   typedef struct packed {
      logic [2:0]  code;
      logic [10:0] div;
   } vec_t;
   localparam vec_t VEC [5] = '{
      '{3'd0, 11'd4}, '{3'd1, 11'd16}, '{3'd2, 11'd64},
      '{3'd3, 11'd256}, '{3'd4, 11'd1024}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic rtc_pulse();
      @(negedge clk); rtc_tick = 1'b1;
      @(negedge clk); rtc_tick = 1'b0;
   endtask

   task automatic pin_set(input logic v);
      @(negedge clk); ext_pin = v;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [31:0] ctl(input logic ie, input logic [1:0] ed,
                                       input logic [2:0] src, input logic ce,
                                       input logic uf, input logic cf);
      return {23'd0, cf, uf, ce, src, ed, ie};
   endfunction

   function automatic int unsigned bitv(input logic [31:0] w, input int b);
      return int'(w[b]);
   endfunction

   initial begin
      #(200000 * 20);
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R1 reset values
      rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
      rd(2'd1, v); chk("R1 counter", v, 32'hFFFF_FFFF);
      rd(2'd2, v); chk("R1 reload", v, 32'hFFFF_FFFF);
      rd(2'd3, v); chk("R1 capture", v, 32'h0);
      chk("R1 irq", irq, 0);
      @(negedge clk); rst = 1'b0;

      // R2 divided sources, table driven
      foreach (VEC[i]) begin
         wr(2'd0, ctl(0, 2'b00, 3'd5, 0, 0, 0));
         wr(2'd1, 32'd100);
         wr(2'd0, ctl(0, 2'b00, VEC[i].code, 0, 0, 0));
         repeat (int'(VEC[i].div) - 1) @(negedge clk);
         rd(2'd1, v); chk("R2 before first tick", v, 32'd100);
         @(negedge clk);
         rd(2'd1, v); chk("R2 first tick", v, 32'd99);
         repeat (int'(VEC[i].div)) @(negedge clk);
         rd(2'd1, v); chk("R2 second tick", v, 32'd98);
      end

      // R6 reserved code
      wr(2'd0, ctl(0, 2'b00, 3'd5, 0, 0, 0));
      wr(2'd1, 32'd40);
      repeat (1100) @(negedge clk);
      rd(2'd1, v); chk("R6 reserved holds", v, 32'd40);

      // R7 / R3 / R4 / R5 underflow via RTC ticks
      wr(2'd0, ctl(0, 2'b00, 3'd6, 0, 0, 0));
      wr(2'd2, 32'd5);
      wr(2'd1, 32'd1);
      rtc_pulse();
      rd(2'd1, v); chk("R7 rtc decrement", v, 32'd0);
      rd(2'd0, v); chk("R3 no flag at zero", bitv(v, 7), 0);
      rtc_pulse();
      rd(2'd1, v); chk("R3 reload", v, 32'd5);
      rd(2'd0, v); chk("R3 underflow flag", bitv(v, 7), 1);
      chk("R4 irq gated off", irq, 0);
      wr(2'd0, ctl(1, 2'b00, 3'd6, 0, 1, 0));
      chk("R4 irq on", irq, 1);
      rd(2'd0, v); chk("R5 write one keeps flag", bitv(v, 7), 1);
      wr(2'd0, ctl(1, 2'b00, 3'd6, 0, 0, 0));
      rd(2'd0, v); chk("R5 write zero clears", bitv(v, 7), 0);
      chk("R4 irq off after clear", irq, 0);

      // R10 standby
      wr(2'd0, ctl(0, 2'b00, 3'd5, 0, 0, 0));
      wr(2'd1, 32'd50);
      standby = 1'b1;
      wr(2'd0, ctl(0, 2'b00, 3'd0, 0, 0, 0));
      repeat (40) @(negedge clk);
      rd(2'd1, v); chk("R10 standby halts divider", v, 32'd50);
      wr(2'd0, ctl(0, 2'b00, 3'd6, 0, 0, 0));
      rtc_pulse();
      rd(2'd1, v); chk("R10 rtc runs in standby", v, 32'd49);
      standby = 1'b0;

      // R8 external source with edge selection
      wr(2'd0, ctl(0, 2'b00, 3'd5, 0, 0, 0));
      wr(2'd1, 32'd20);
      wr(2'd0, ctl(0, 2'b00, 3'd7, 0, 0, 0));
      @(negedge clk); ext_pin = 1'b1;
      repeat (2) @(negedge clk);
      rd(2'd1, v); chk("R8 latency not yet", v, 32'd20);
      @(negedge clk);
      rd(2'd1, v); chk("R8 rise counted at E2", v, 32'd19);
      pin_set(1'b0);
      rd(2'd1, v); chk("R8 fall ignored on rise mode", v, 32'd19);
      wr(2'd0, ctl(0, 2'b01, 3'd7, 0, 0, 0));
      pin_set(1'b1);
      rd(2'd1, v); chk("R8 rise ignored on fall mode", v, 32'd19);
      pin_set(1'b0);
      rd(2'd1, v); chk("R8 fall counted", v, 32'd18);
      wr(2'd0, ctl(0, 2'b10, 3'd7, 0, 0, 0));
      pin_set(1'b1);
      rd(2'd1, v); chk("R8 both: rise", v, 32'd17);
      pin_set(1'b0);
      rd(2'd1, v); chk("R8 both: fall", v, 32'd16);

      // R9 capture
      wr(2'd0, ctl(0, 2'b00, 3'd5, 1, 0, 0));
      wr(2'd1, 32'd77);
      pin_set(1'b1);
      rd(2'd3, v); chk("R9 capture value", v, 32'd77);
      rd(2'd0, v); chk("R9 capture flag", bitv(v, 8), 1);
      pin_set(1'b0);
      wr(2'd1, 32'd60);
      pin_set(1'b1);
      rd(2'd3, v); chk("R9 held while flag set", v, 32'd77);
      wr(2'd0, ctl(0, 2'b00, 3'd5, 1, 0, 0));
      rd(2'd0, v); chk("R9 R5 capture flag clear", bitv(v, 8), 0);
      pin_set(1'b0);
      pin_set(1'b1);
      rd(2'd3, v); chk("R9 recapture after clear", v, 32'd60);
      wr(2'd0, ctl(0, 2'b00, 3'd5, 0, 0, 0));
      wr(2'd1, 32'd33);
      pin_set(1'b0);
      pin_set(1'b1);
      rd(2'd3, v); chk("R9 disabled no capture", v, 32'd60);
      rd(2'd0, v); chk("R9 disabled no flag", bitv(v, 8), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule